// File: doc/BRIEF.md
# Branch Decode and Delay-Slot Control

This block sits in the decode stage of a five-stage pipeline in which every control transfer is followed by exactly one delay-slot instruction. It looks at the 32-bit instruction currently in decode and classifies it as one of three kinds: an absolute call, a conditional branch relative to the PC, or a return that jumps through register values. It extracts the fields of that instruction and forms the destination address. For conditional branches, it tests the 4-bit condition against the ALU flags. It then registers three results: a taken decision, the target address, and a request to suppress the delay slot.

Only conditional branches can carry the annul bit. When that bit is set and the branch is not taken, the instruction in the delay slot must be kept out of decode. In every other case the delay slot runs normally. Calls and returns are always taken, and they never annul their delay slot. For a return, the block presents the two register address fields combinationally so that the register file can be read in the same cycle. The operand values then come back to this block as inputs.

Top module: `br_decode_unit`

## Requirements
- R1: While `rst` is high, the registered outputs are cleared on each clock edge: `br_kind_o`=0, `br_taken_o`=0, `br_target_o`=0 and `slot_annul_o`=0.
- R2: An instruction with bits [31:30]=2'b01 is a call. The block reports kind 1, taken=1 and target = bits [29:0] followed by two zero bits. `slot_annul_o` stays 0 whatever bit 19 holds.
- R3: An instruction with bits [31:24]=8'h08 is a conditional branch and is reported as kind 2. Its condition is bits [23:20], its annul flag is bit 19 and its signed offset is bits [18:0].
- R4: The target of a conditional branch is the PC plus the 19-bit offset after sign extension and a left shift by two, taken modulo 2^32.
- R5: With `flags_i`={N,Z,C,V}, the conditions are: 0 never, 1 Z, 2 Z|(N^V), 3 N^V, 4 C|Z, 5 C, 6 N, 7 V, 8 always, 9 !Z, 10 !(Z|(N^V)), 11 !(N^V), 12 !(C|Z), 13 !C, 14 !N, 15 !V. A conditional branch is taken exactly when its condition holds.
- R6: `slot_annul_o` is 1 only for a conditional branch whose annul bit is 1 and that is not taken. It is 0 for every other case.
- R7: An instruction with bits [31:24]=8'h0C is a return and is reported as kind 3, taken=1, `slot_annul_o`=0. Its target is (`ret_a_i`+`ret_b_i`) with bits [1:0] cleared. `ret_ra_o` shows bits [23:19] and `ret_rb_o` shows bits [18:14] combinationally, in the same cycle.
- R8: When the instruction matches none of the three kinds, or when `dec_valid_i` is 0, the block reports kind 0 with taken=0 and `slot_annul_o`=0.
- R9: The kind, taken, target and annul results appear at the clock edge that samples the instruction. Before that edge they keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid_i | input | 1 | Decode slot holds a valid instruction |
| instr_i | input | 32 | Instruction in decode |
| pc_i | input | 32 | Address of that instruction |
| flags_i | input | 4 | ALU flags {N,Z,C,V} |
| ret_a_i | input | 32 | Value read for the first return register |
| ret_b_i | input | 32 | Value read for the second return register |
| ret_ra_o | output | 5 | First register address field (combinational) |
| ret_rb_o | output | 5 | Second register address field (combinational) |
| br_kind_o | output | 2 | 0 none, 1 call, 2 conditional, 3 return |
| br_taken_o | output | 1 | Transfer is taken |
| br_target_o | output | 32 | Destination address |
| slot_annul_o | output | 1 | Keep the delay-slot instruction out of decode |

## Verification
The register-field outputs have no latency, so the bench compares them a moment after it drives an instruction, before any clock edge. The kind, taken, target and annul results pass through exactly one register. The bench therefore drives each input on a falling edge and compares the results on the next falling edge, which is half a cycle after the capturing edge. In the same step, just before the capturing edge, it confirms that the results still hold the values from the previous instruction. Conditional branches are swept over all 16 condition codes, all 16 flag patterns and both annul values, and the offset extremes and PC wrap-around are covered separately.

// File: rtl/brdec_pkg.sv
package brdec_pkg;

  // Instruction layout widths (fixed by the encoding)
  localparam int unsigned ILEN     = 32;
  localparam int unsigned AW       = 32;
  localparam int unsigned OFF_W    = 19;
  localparam int unsigned ABS_W    = 30;
  localparam int unsigned RADDR_W  = 5;
  localparam int unsigned COND_W   = 4;
  localparam int unsigned FLAG_W   = 4;
  localparam int unsigned SEXT_W   = AW - OFF_W - 2;

  // Opcode values; decode priority is call, then conditional, then return
  localparam logic [1:0] CALL_OP = 2'b01;
  localparam logic [7:0] COND_OP = 8'h08;
  localparam logic [7:0] RET_OP  = 8'h0C;

  typedef enum logic [1:0] {
    BK_NONE = 2'd0,
    BK_CALL = 2'd1,
    BK_COND = 2'd2,
    BK_RET  = 2'd3
  } br_kind_e;

  typedef struct packed {
    br_kind_e             kind;
    logic [COND_W-1:0]    cond;
    logic                 annul;
    logic [OFF_W-1:0]     off;
    logic [ABS_W-1:0]     abs_addr;
    logic [RADDR_W-1:0]   ra;
    logic [RADDR_W-1:0]   rb;
  } br_fields_t;

endpackage

// File: rtl/br_field_decode.sv
module br_field_decode
  import brdec_pkg::*;
(
  input  logic [ILEN-1:0] instr_i,
  output br_fields_t      fields_o
);

  always_comb begin
    fields_o.cond     = instr_i[23:20];
    fields_o.annul    = instr_i[19];
    fields_o.off      = instr_i[OFF_W-1:0];
    fields_o.abs_addr = instr_i[ABS_W-1:0];
    fields_o.ra       = instr_i[23:19];
    fields_o.rb       = instr_i[18:14];
    if (instr_i[31:30] == CALL_OP)
      fields_o.kind = BK_CALL;
    else if (instr_i[31:24] == COND_OP)
      fields_o.kind = BK_COND;
    else if (instr_i[31:24] == RET_OP)
      fields_o.kind = BK_RET;
    else
      fields_o.kind = BK_NONE;
  end

endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import brdec_pkg::*;
(
  input  logic [COND_W-1:0] cond_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              pass_o
);

  logic fn, fz, fc, fv;
  logic base;

  assign fn = flags_i[3];
  assign fz = flags_i[2];
  assign fc = flags_i[1];
  assign fv = flags_i[0];

  // Low three bits select a flag test; the top bit inverts it
  always_comb begin
    unique case (cond_i[2:0])
      3'd0:    base = 1'b0;
      3'd1:    base = fz;
      3'd2:    base = fz | (fn ^ fv);
      3'd3:    base = fn ^ fv;
      3'd4:    base = fc | fz;
      3'd5:    base = fc;
      3'd6:    base = fn;
      default: base = fv;
    endcase
  end

  assign pass_o = cond_i[3] ^ base;

endmodule

// File: rtl/br_target_gen.sv
module br_target_gen
  import brdec_pkg::*;
(
  input  br_fields_t    fields_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] ret_a_i,
  input  logic [AW-1:0] ret_b_i,
  output logic [AW-1:0] target_o
);

  logic [AW-1:0] rel_disp;
  logic [AW-1:0] ret_sum;

  assign rel_disp = {{SEXT_W{fields_i.off[OFF_W-1]}}, fields_i.off, 2'b00};
  assign ret_sum  = ret_a_i + ret_b_i;

  always_comb begin
    unique case (fields_i.kind)
      BK_CALL: target_o = {fields_i.abs_addr, 2'b00};
      BK_COND: target_o = pc_i + rel_disp;
      BK_RET:  target_o = {ret_sum[AW-1:2], 2'b00};
      default: target_o = '0;
    endcase
  end

endmodule

// File: rtl/br_decode_unit.sv
module br_decode_unit
  import brdec_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                dec_valid_i,
  input  logic [31:0]         instr_i,
  input  logic [31:0]         pc_i,
  input  logic [3:0]          flags_i,
  input  logic [31:0]         ret_a_i,
  input  logic [31:0]         ret_b_i,
  output logic [4:0]          ret_ra_o,
  output logic [4:0]          ret_rb_o,
  output logic [1:0]          br_kind_o,
  output logic                br_taken_o,
  output logic [31:0]         br_target_o,
  output logic                slot_annul_o
);

  br_fields_t    fld;
  logic          cond_pass;
  logic [AW-1:0] tgt;
  logic          taken_nxt;
  logic          annul_nxt;

  br_field_decode u_fields (
    .instr_i  (instr_i),
    .fields_o (fld)
  );

  br_cond_eval u_cond (
    .cond_i  (fld.cond),
    .flags_i (flags_i),
    .pass_o  (cond_pass)
  );

  br_target_gen u_tgt (
    .fields_i (fld),
    .pc_i     (pc_i),
    .ret_a_i  (ret_a_i),
    .ret_b_i  (ret_b_i),
    .target_o (tgt)
  );

  // Register-file read addresses leave without a register
  assign ret_ra_o = fld.ra;
  assign ret_rb_o = fld.rb;

  always_comb begin
    unique case (fld.kind)
      BK_CALL, BK_RET: taken_nxt = 1'b1;
      BK_COND:         taken_nxt = cond_pass;
      default:         taken_nxt = 1'b0;
    endcase
    annul_nxt = (fld.kind == BK_COND) && fld.annul && !cond_pass;
  end

  always_ff @(posedge clk) begin
    if (rst || !dec_valid_i) begin
      br_kind_o    <= BK_NONE;
      br_taken_o   <= 1'b0;
      br_target_o  <= '0;
      slot_annul_o <= 1'b0;
    end else begin
      br_kind_o    <= fld.kind;
      br_taken_o   <= taken_nxt;
      br_target_o  <= tgt;
      slot_annul_o <= annul_nxt;
    end
  end

  // R1: reset clears the registered results
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (br_kind_o == BK_NONE && !br_taken_o && !slot_annul_o && br_target_o == '0));

  // R2: a call is always taken
  a_r2_call_taken: assert property (@(posedge clk) disable iff (rst)
    (br_kind_o == BK_CALL) |-> br_taken_o);

  // R7: a return is always taken and never annuls
  a_r7_ret_taken: assert property (@(posedge clk) disable iff (rst)
    (br_kind_o == BK_RET) |-> (br_taken_o && !slot_annul_o));

  // R6: annul only on a not-taken conditional branch
  a_r6_annul_cond_only: assert property (@(posedge clk) disable iff (rst)
    slot_annul_o |-> (br_kind_o == BK_COND && !br_taken_o));

  // R8: no transfer means quiet outputs
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (br_kind_o == BK_NONE) |-> (!br_taken_o && !slot_annul_o));

  // R9: an invalid decode slot yields nothing on the next edge
  a_r9_invalid_next: assert property (@(posedge clk) disable iff (rst)
    !dec_valid_i |=> (br_kind_o == BK_NONE));

endmodule

// File: tb/sim_br_decode_unit.sv
module sim_br_decode_unit;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst;
  logic        dec_valid_i;
  logic [31:0] instr_i, pc_i, ret_a_i, ret_b_i;
  logic [3:0]  flags_i;
  logic [4:0]  ret_ra_o, ret_rb_o;
  logic [1:0]  br_kind_o;
  logic        br_taken_o;
  logic [31:0] br_target_o;
  logic        slot_annul_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  br_decode_unit u0 (
    .clk(clk), .rst(rst), .dec_valid_i(dec_valid_i), .instr_i(instr_i),
    .pc_i(pc_i), .flags_i(flags_i), .ret_a_i(ret_a_i), .ret_b_i(ret_b_i),
    .ret_ra_o(ret_ra_o), .ret_rb_o(ret_rb_o), .br_kind_o(br_kind_o),
    .br_taken_o(br_taken_o), .br_target_o(br_target_o), .slot_annul_o(slot_annul_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic cond_ref(input int c, input logic [3:0] f);
    logic n, z, cf, v;
    {n, z, cf, v} = f;
    case (c)
      0: return 1'b0;        1: return z;
      2: return z | (n ^ v); 3: return n ^ v;
      4: return cf | z;      5: return cf;
      6: return n;           7: return v;
      8: return 1'b1;        9: return !z;
      10: return !(z | (n ^ v)); 11: return !(n ^ v);
      12: return !(cf | z);  13: return !cf;
      14: return !n;         default: return !v;
    endcase
  endfunction

  // Drive on a falling edge, results are read on the next falling edge
  task automatic step(input logic vld, input logic [31:0] ins, input logic [31:0] pc,
                      input logic [3:0] fl, input logic [31:0] a, input logic [31:0] b);
    dec_valid_i = vld; instr_i = ins; pc_i = pc; flags_i = fl; ret_a_i = a; ret_b_i = b;
    @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic [1:0] k, input logic t,
                            input logic [31:0] tg, input logic an);
    chk({req, " kind"}, {30'd0, br_kind_o}, {30'd0, k});
    chk({req, " taken"}, {31'd0, br_taken_o}, {31'd0, t});
    chk({req, " target"}, br_target_o, tg);
    chk({req, " annul"}, {31'd0, slot_annul_o}, {31'd0, an});
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] ins, pc, sx;
    logic [18:0] off;
    logic        exp_t;
    rst = 1'b1;
    step(1'b0, 32'h0, 32'h0, 4'h0, 32'h0, 32'h0);
    step(1'b0, 32'h0, 32'h0, 4'h0, 32'h0, 32'h0);
    expect_out("R1 reset", 2'd0, 1'b0, 32'h0, 1'b0);
    rst = 1'b0;

    // R3 R4 R5 R6: every condition, flag pattern and annul value
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        for (int an = 0; an < 2; an++) begin
          off = 19'((c * 16 + f) * 977 + an * 131071);
          ins = {8'h08, 4'(c), 1'(an), off};
          pc  = 32'h0004_0000 + 32'((c * 32 + f * 2 + an) * 4);
          sx  = {{13{off[18]}}, off};
          exp_t = cond_ref(c, 4'(f));
          step(1'b1, ins, pc, 4'(f), 32'h0, 32'h0);
          expect_out("R3 R4 R5 R6 cond", 2'd2, exp_t, pc + sx * 4,
                     (an == 1) && !exp_t);
        end
      end
    end

    // R4: offset extremes and address wrap
    step(1'b1, {8'h08, 4'd8, 1'b0, 19'h3FFFF}, 32'h0000_0100, 4'h0, 0, 0);
    expect_out("R4 max positive", 2'd2, 1'b1, 32'h0000_0100 + 32'h000F_FFFC, 1'b0);
    step(1'b1, {8'h08, 4'd8, 1'b0, 19'h40000}, 32'h0010_0000, 4'h0, 0, 0);
    expect_out("R4 most negative", 2'd2, 1'b1, 32'h0000_0000, 1'b0);
    step(1'b1, {8'h08, 4'd8, 1'b1, 19'h7FFFF}, 32'h0000_0000, 4'h0, 0, 0);
    expect_out("R4 wrap below zero", 2'd2, 1'b1, 32'hFFFF_FFFC, 1'b0);
    step(1'b1, {8'h08, 4'd0, 1'b1, 19'h00001}, 32'hFFFF_FFFC, 4'hF, 0, 0);
    expect_out("R4 R6 wrap above top never", 2'd2, 1'b0, 32'h0000_0000, 1'b1);

    // R2: calls, annul position set or clear
    step(1'b1, {2'b01, 30'h0}, 32'h1234, 4'h0, 0, 0);
    expect_out("R2 call zero", 2'd1, 1'b1, 32'h0, 1'b0);
    step(1'b1, {2'b01, 30'h3FFF_FFFF}, 32'h1234, 4'h0, 0, 0);
    expect_out("R2 call top", 2'd1, 1'b1, 32'hFFFF_FFFC, 1'b0);
    step(1'b1, {2'b01, 30'h0128_0000}, 32'h0, 4'h0, 0, 0);
    expect_out("R2 call bit19 set", 2'd1, 1'b1, 32'h04A0_0000, 1'b0);

    // R7: returns with combinational register fields
    for (int r = 0; r < 32; r += 7) begin
      ins = {8'h0C, 5'(r), 5'(31 - r), 14'h2A5};
      dec_valid_i = 1'b1; instr_i = ins; pc_i = 32'h0; flags_i = 4'h0;
      ret_a_i = 32'h1000_0003 * 32'(r + 1); ret_b_i = 32'hFFFF_FFF5 + 32'(r);
      #1;
      chk("R7 ra field", {27'd0, ret_ra_o}, 32'(r));
      chk("R7 rb field", {27'd0, ret_rb_o}, 32'(31 - r));
      @(negedge clk);
      expect_out("R7 ret", 2'd3, 1'b1,
                 (32'h1000_0003 * 32'(r + 1) + 32'hFFFF_FFF5 + 32'(r)) & 32'hFFFF_FFFC, 1'b0);
    end

    // R8: non-transfer encodings and an invalid slot
    step(1'b1, 32'h0000_0000, 32'h40, 4'h0, 0, 0);
    expect_out("R8 zero word", 2'd0, 1'b0, 32'h0, 1'b0);
    step(1'b1, 32'hC808_0000, 32'h40, 4'h0, 0, 0);
    expect_out("R8 top bits 11", 2'd0, 1'b0, 32'h0, 1'b0);
    step(1'b1, 32'h0988_0001, 32'h40, 4'h0, 0, 0);
    expect_out("R8 near opcode", 2'd0, 1'b0, 32'h0, 1'b0);
    step(1'b0, {8'h08, 4'd0, 1'b1, 19'h10}, 32'h40, 4'h0, 0, 0);
    expect_out("R8 invalid annul branch", 2'd0, 1'b0, 32'h0, 1'b0);

    // R9: results hold until the capturing edge
    step(1'b1, {2'b01, 30'h10}, 32'h0, 4'h0, 0, 0);
    dec_valid_i = 1'b1; instr_i = {8'h08, 4'd0, 1'b1, 19'h4};
    #(CLK_PERIOD/2 - 1);
    expect_out("R9 hold before edge", 2'd1, 1'b1, 32'h40, 1'b0);
    @(negedge clk);
    expect_out("R9 after edge", 2'd2, 1'b0, pc_i + 32'h10, 1'b1);

    // R1: reset after activity
    rst = 1'b1;
    step(1'b1, {2'b01, 30'h55}, 32'h0, 4'h0, 0, 0);
    expect_out("R1 reset mid run", 2'd0, 1'b0, 32'h0, 1'b0);
    rst = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule